// File: doc/BRIEF.md
# Byte-wide SPI master/slave port

This block moves one byte at a time over a four-wire synchronous serial link. It can lead the link or follow it. As leader it drives the serial clock and the outgoing data line, and it samples the returning line. The select line is not driven by the block and stays with software. As follower it takes the clock, the incoming data line and an active-low select from the link, and it drives the returning line only while it is selected. Bits travel most significant first. A single data register serves both directions. Software writes the byte to send into it, and the byte that arrives replaces it when the eighth bit is complete.

Static control inputs pick the role, the idle level of the clock, the clock phase and, for the leader only, one of four bit rates. These rates are 6, 12, 24 and 192 core clocks per serial clock period. A completion flag is raised at the end of every byte and is offered as an interrupt request. The next accepted write to the data register clears the flag.

Top module: `spi_port`

## Requirements
- R1: After reset the data register reads 0, `done`, `irq` and `busy` are 0.
- R2: In master mode (`cfg_slave`=0), a write while `busy`=0 loads the data register and raises `busy` on the next cycle. The block then makes exactly 16 `sck_o` transitions spaced H core clocks apart, the first H clocks after the write, where H is 3, 6, 12 or 96 for `cfg_rate` 0, 1, 2 or 3. `busy` falls together with the 16th transition. Whenever `busy`=0, `sck_o` rests at `cfg_cpol`.
- R3: In master mode the written byte leaves on `mosi_o` MSB first. With `cfg_cpha`=0 a bit is valid before the leading clock transition (the one away from `cfg_cpol`) and changes only on trailing transitions. With `cfg_cpha`=1 a bit changes on the leading transition.
- R4: In master mode `miso_i` is sampled on leading transitions when `cfg_cpha`=0 and on trailing transitions when `cfg_cpha`=1. The eight samples, MSB first, are in the data register once `busy` falls.
- R5: `done` and `irq` rise at the end of each byte, and only as a transfer finishes. An accepted write clears them.
- R6: A write while `busy`=1 is ignored: neither the outgoing bit stream nor the received byte changes.
- R7: In slave mode (`cfg_slave`=1), with `ss_n_i` low, the block shifts the data register out on `miso_o` MSB first and shifts `mosi_i` in with the same edge rules as R3/R4. It sets `done` after eight bits. A write while `ss_n_i` is high loads the data register.
- R8: `sck_oe` and `mosi_oe` are 1 exactly in master mode. `miso_oe` is 1 only in slave mode while selected. `cfg_rate` has no effect in slave mode.
- R9: In slave mode, clock transitions after the eighth bit are ignored until `ss_n_i` goes high. Raising `ss_n_i` mid-byte discards the partial byte, leaves `done` and the data register unchanged, and restarts bit alignment at the MSB.
- R10: In master mode `ss_n_i`, `sck_i` and `mosi_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_slave | input | 1 | 1 = follower role, 0 = leader role |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0 = sample on leading transition, 1 = sample on trailing transition |
| cfg_rate | input | 2 | Leader bit-rate select (0 fastest, 3 slowest) |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | DW | Byte to send |
| rd_data | output | DW | Data register contents |
| busy | output | 1 | Leader: transfer running. Follower: selected |
| done | output | 1 | Byte-complete flag |
| irq | output | 1 | Interrupt request, follows the complete flag |
| sck_i | input | 1 | Serial clock from the link (follower) |
| sck_o | output | 1 | Serial clock to the link (leader) |
| sck_oe | output | 1 | Drive enable for the serial clock |
| mosi_i | input | 1 | Leader-to-follower data in (follower) |
| mosi_o | output | 1 | Leader-to-follower data out (leader) |
| mosi_oe | output | 1 | Drive enable for leader-to-follower data |
| miso_i | input | 1 | Follower-to-leader data in (leader) |
| miso_o | output | 1 | Follower-to-leader data out (follower) |
| miso_oe | output | 1 | Drive enable for follower-to-leader data |
| ss_n_i | input | 1 | Active-low select (follower) |

## Verification
The hardest condition to reach is a follower whose select is dropped part way through a byte and then reasserted. Only then does stale bit alignment show up, as a rotated received byte or a spurious completion flag. The bench reaches it with a directed sequence: three clock bits, a select release, then a full byte, with the follower's transmitted stream checked as well. A second situation hard to reach is a register write that lands in the middle of a leader transfer. The bench places one at a fixed offset inside a transfer and checks that both bit streams come out unchanged. Random seeded runs then vary polarity, phase, rate and data.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef enum logic [1:0] {
    RATE_FAST  = 2'd0,
    RATE_MID   = 2'd1,
    RATE_SLOW  = 2'd2,
    RATE_CRAWL = 2'd3
  } rate_e;

  // multiple of the base half period for each rate step
  function automatic int unsigned half_mult(input rate_e r);
    case (r)
      RATE_FAST:  half_mult = 1;
      RATE_MID:   half_mult = 2;
      RATE_SLOW:  half_mult = 4;
      default:    half_mult = 32;
    endcase
  endfunction

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_port_pkg::*;
#(
  parameter int unsigned BASE = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int unsigned MAXH = BASE * 32;
  localparam int unsigned CW   = $clog2(MAXH + 1);

  logic [CW-1:0] cnt_q, cnt_n, lim;

  always_comb begin
    lim  = CW'(BASE * half_mult(rate_e'(rate)) - 1);
    tick = run && (cnt_q == lim);
    if (!run || tick) cnt_n = '0;
    else              cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[g];
        s2_q <= RST_VAL[g];
      end else begin
        s1_q <= din[g];
        s2_q <= s1_q;
      end
    end
    assign dout[g] = s2_q;
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpha,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          idle,
  input  logic          ev,
  input  logic          ev_lead,
  input  logic          din,
  output logic          out_bit,
  output logic [DW-1:0] data,
  output logic          complete
);
  localparam int unsigned EW = $clog2(2 * DW + 1);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2 * DW);

  logic [DW-1:0] sh_q, sh_n, data_q, data_n;
  logic [EW-1:0] ecnt_q, ecnt_n;
  logic          rxb_q, rxb_n, out_q, out_n;
  logic          step, in_bit;
  logic [DW-1:0] shifted;

  always_comb begin
    sh_n     = sh_q;
    data_n   = data_q;
    ecnt_n   = ecnt_q;
    rxb_n    = rxb_q;
    out_n    = out_q;
    step     = !load && !idle && ev && (ecnt_q != LAST_EDGE);
    in_bit   = cpha ? din : rxb_q;
    shifted  = {sh_q[DW-2:0], in_bit};
    complete = step && !ev_lead && (ecnt_q == LAST_EDGE - 1'b1);
    if (load) begin
      sh_n   = load_data;
      data_n = load_data;
      out_n  = load_data[DW-1];
      ecnt_n = '0;
    end else if (idle) begin
      sh_n   = data_q;
      out_n  = data_q[DW-1];
      ecnt_n = '0;
    end else if (step) begin
      ecnt_n = ecnt_q + 1'b1;
      if (ev_lead) begin
        if (!cpha) rxb_n = din;
        else       out_n = sh_q[DW-1];
      end else begin
        sh_n = shifted;
        if (!cpha) out_n = sh_q[DW-2];
        if (complete) data_n = shifted;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      data_q <= '0;
      ecnt_q <= '0;
      rxb_q  <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      data_q <= data_n;
      ecnt_q <= ecnt_n;
      rxb_q  <= rxb_n;
      out_q  <= out_n;
    end
  end

  assign out_bit = out_q;
  assign data    = data_q;
endmodule

// File: rtl/spi_port.sv
module spi_port #(
  parameter int unsigned DW   = 8,
  parameter int unsigned BASE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_slave,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic [1:0]    cfg_rate,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done,
  output logic          irq,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          ss_n_i
);
  logic       master;
  logic [2:0] sync_out;
  logic       ss_s, sck_s, mosi_s;
  logic       sck_d_q;
  logic       busy_q, busy_n, sck_q, sck_n, done_q, done_n;
  logic       tick, wr_ok, ev, ev_lead, idle, din, out_bit, complete;

  assign master = !cfg_slave;

  spi_in_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
    .clk (clk), .rst_n (rst_n),
    .din ({ss_n_i, sck_i, mosi_i}),
    .dout(sync_out)
  );
  assign {ss_s, sck_s, mosi_s} = sync_out;

  spi_rate_gen #(.BASE(BASE)) u_rate (
    .clk (clk), .rst_n (rst_n),
    .run (master && busy_q),
    .rate(cfg_rate),
    .tick(tick)
  );

  always_comb begin
    busy    = master ? busy_q : !ss_s;
    wr_ok   = wr_en && !busy;
    idle    = master ? (!busy_q && !wr_ok) : ss_s;
    din     = master ? miso_i : mosi_s;
    if (master) begin
      ev      = tick;
      ev_lead = (sck_q == cfg_cpol);
    end else begin
      ev      = !ss_s && (sck_s != sck_d_q);
      ev_lead = (sck_s != cfg_cpol);
    end

    busy_n = busy_q;
    if (!master)      busy_n = 1'b0;
    else if (wr_ok)   busy_n = 1'b1;
    else if (complete) busy_n = 1'b0;

    if (master && busy_q) sck_n = tick ? !sck_q : sck_q;
    else                  sck_n = cfg_cpol;

    done_n = done_q;
    if (complete)   done_n = 1'b1;
    else if (wr_ok) done_n = 1'b0;
  end

  spi_shift_core #(.DW(DW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpha     (cfg_cpha),
    .load     (wr_ok),
    .load_data(wr_data),
    .idle     (idle),
    .ev       (ev),
    .ev_lead  (ev_lead),
    .din      (din),
    .out_bit  (out_bit),
    .data     (rd_data),
    .complete (complete)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sck_q   <= 1'b0;
      done_q  <= 1'b0;
      sck_d_q <= 1'b0;
    end else begin
      busy_q  <= busy_n;
      sck_q   <= sck_n;
      done_q  <= done_n;
      sck_d_q <= sck_s;
    end
  end

  assign done    = done_q;
  assign irq     = done_q;
  assign sck_o   = sck_q;
  assign sck_oe  = master;
  assign mosi_o  = out_bit;
  assign mosi_oe = master;
  assign miso_o  = out_bit;
  assign miso_oe = !master && !ss_s;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_slave,
  input logic cfg_cpol,
  input logic cfg_cpha,
  input logic wr_en,
  input logic busy,
  input logic done,
  input logic sck_o,
  input logic mosi_o
);
  // R2: leader clock rests at the idle level between transfers
  a_r2_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_slave && $past(!cfg_slave) && !busy && $past(!busy) && $past(rst_n)
     && $stable(cfg_cpol)) |-> (sck_o == cfg_cpol));

  // R2: no two clock transitions on consecutive cycles during a transfer
  a_r2_half_min: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_slave && $past(!cfg_slave) && busy && (sck_o != $past(sck_o)))
    |=> $stable(sck_o));

  // R3: with phase 0 the data line holds across a leading transition
  a_r3_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_slave && busy && !cfg_cpha && $stable(cfg_cpha) && $stable(cfg_cpol)
     && (sck_o != $past(sck_o)) && (sck_o != cfg_cpol)) |-> $stable(mosi_o));

  // R5: an accepted write clears the completion flag
  a_r5_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy) |=> !done);

  // R5: the completion flag only rises as a transfer ends
  a_r5_done_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
endmodule

bind spi_port spi_port_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_slave(cfg_slave),
  .cfg_cpol (cfg_cpol),
  .cfg_cpha (cfg_cpha),
  .wr_en    (wr_en),
  .busy     (busy),
  .done     (done),
  .sck_o    (sck_o),
  .mosi_o   (mosi_o)
);

// File: tb/sim_spi_port.sv
module sim_spi_port;
  localparam int SH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_slave = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [1:0] cfg_rate = 2'd0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic busy, done, irq;
  logic sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;
  logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  spi_port u0 (
    .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_rate(cfg_rate), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .busy(busy), .done(done), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i)
  );

  function automatic int half_of(input logic [1:0] r);
    case (r)
      2'd0: return 3;
      2'd1: return 6;
      2'd2: return 12;
      default: return 96;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  // bench acts as the follower while the block leads
  task automatic run_master(input logic [7:0] tx, input logic [7:0] sb,
                            input bit pol, input bit pha, input logic [1:0] rt,
                            input bit inject);
    int h, n, last, edges, kl, kt;
    bit gap_ok;
    logic prev;
    logic [7:0] got;
    h = half_of(rt);
    @(negedge clk);
    cfg_slave = 1'b0; cfg_cpol = pol; cfg_cpha = pha; cfg_rate = rt;
    miso_i = pha ? 1'b0 : sb[7];
    repeat (3) @(negedge clk);
    chk(sck_o == pol, "R2 idle level", sck_o, pol);
    chk(sck_oe && mosi_oe && !miso_oe, "R8 leader enables", {sck_oe, mosi_oe, miso_oe}, 3'b110);
    wr_en = 1'b1; wr_data = tx;
    @(negedge clk);
    wr_en = 1'b0;
    chk(busy == 1'b1, "R2 busy after write", busy, 1);
    chk(done == 1'b0, "R5 cleared by write", done, 0);
    n = 0; last = 0; edges = 0; kl = 0; kt = 0; gap_ok = 1'b1; got = 8'h00; prev = pol;
    while (edges < 16 && n < 5000) begin
      if (sck_o != prev) begin
        edges++;
        if (n - last != h) gap_ok = 1'b0;
        last = n;
        if (sck_o != pol) begin
          if (!pha) got = {got[6:0], mosi_o};
          else if (kl < 8) miso_i = sb[7-kl];
          kl++;
        end else begin
          if (pha) got = {got[6:0], mosi_o};
          else begin
            kt++;
            if (kt < 8) miso_i = sb[7-kt];
          end
        end
      end
      prev = sck_o;
      // R10: follower-side inputs toggle freely in leader mode
      sck_i = 1'($urandom); ss_n_i = 1'($urandom); mosi_i = 1'($urandom);
      if (inject && n == h + 1) begin wr_en = 1'b1; wr_data = ~tx; end
      else wr_en = 1'b0;
      if (edges < 16) begin
        @(negedge clk);
        n++;
      end
    end
    wr_en = 1'b0; ss_n_i = 1'b1;
    chk(edges == 16, "R2 transition count", edges, 16);
    chk(gap_ok, "R2 transition spacing", n, 16 * h);
    chk(busy == 1'b0, "R2 busy falls with last transition", busy, 0);
    chk(got == tx, inject ? "R6 stream after ignored write" : "R3 leader stream", got, tx);
    chk(rd_data == sb, inject ? "R6 received after ignored write" : "R4 leader receive", rd_data, sb);
    chk(done && irq, "R5 completion flag", {done, irq}, 2'b11);
    @(negedge clk);
    chk(sck_o == pol, "R2 clock back at idle", sck_o, pol);
  endtask

  // bench acts as leader while the block follows
  task automatic slave_frame(input logic [7:0] mb, input bit pol, input bit pha,
                             input int nb, output logic [7:0] got);
    logic [7:0] g;
    g = 8'h00;
    ss_n_i = 1'b0;
    mosi_i = pha ? 1'b0 : mb[7];
    repeat (SH) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      if (!pha) begin
        sck_i = ~pol;
        g = {g[6:0], miso_o};
        repeat (SH) @(negedge clk);
        sck_i = pol;
        if (i < 7) mosi_i = mb[6-i];
        repeat (SH) @(negedge clk);
      end else begin
        sck_i = ~pol;
        mosi_i = mb[7-i];
        repeat (SH) @(negedge clk);
        g = {g[6:0], miso_o};
        sck_i = pol;
        repeat (SH) @(negedge clk);
      end
    end
    repeat (6) @(negedge clk);
    got = g;
  endtask

  task automatic slave_setup(input logic [7:0] tx, input bit pol, input bit pha);
    @(negedge clk);
    cfg_slave = 1'b1; cfg_cpol = pol; cfg_cpha = pha;
    cfg_rate = 2'($urandom);   // R8: rate must not matter here
    ss_n_i = 1'b1; sck_i = pol; mosi_i = 1'b0;
    repeat (4) @(negedge clk);
    wr_en = 1'b1; wr_data = tx;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_slave(input logic [7:0] tx, input logic [7:0] mb,
                           input bit pol, input bit pha);
    logic [7:0] got;
    slave_setup(tx, pol, pha);
    chk(rd_data == tx, "R7 write while deselected", rd_data, tx);
    chk(!sck_oe && !mosi_oe && !miso_oe, "R8 follower deselected enables",
        {sck_oe, mosi_oe, miso_oe}, 0);
    slave_frame(mb, pol, pha, 8, got);
    chk(miso_oe, "R8 follower drives when selected", miso_oe, 1);
    chk(done && irq, "R7 follower completion", {done, irq}, 2'b11);
    chk(rd_data == mb, "R7 follower receive", rd_data, mb);
    chk(got == tx, "R7 follower stream", got, tx);
    // R9: extra transitions before release are ignored
    sck_i = ~pol; repeat (SH) @(negedge clk);
    sck_i = pol;  repeat (SH) @(negedge clk);
    chk(rd_data == mb && done, "R9 extra edges ignored", rd_data, mb);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(!miso_oe, "R8 follower releases line", miso_oe, 0);
  endtask

  task automatic run_abort(input logic [7:0] tx, input logic [7:0] m1,
                           input logic [7:0] m2, input bit pol, input bit pha);
    logic [7:0] got;
    slave_setup(tx, pol, pha);
    slave_frame(m1, pol, pha, 3, got);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done, "R9 partial byte sets no flag", done, 0);
    chk(rd_data == tx, "R9 partial byte discarded", rd_data, tx);
    slave_frame(m2, pol, pha, 8, got);
    chk(rd_data == m2, "R9 realigned receive", rd_data, m2);
    chk(got == tx, "R9 realigned stream", got, tx);
    chk(done, "R9 flag after full byte", done, 1);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c1a));
    repeat (4) @(negedge clk);
    chk(rd_data == 8'h00, "R1 data after reset", rd_data, 0);
    chk(!done && !irq && !busy, "R1 flags after reset", {done, irq, busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed leader corners: every rate, every mode
    for (int r = 0; r < 4; r++)
      run_master(8'hA5 ^ 8'(r), 8'h3C ^ 8'(r * 17), r[0], r[1], 2'(r), 1'b0);
    run_master(8'h80, 8'h01, 1'b1, 1'b0, 2'd0, 1'b0);
    run_master(8'h01, 8'h80, 1'b0, 1'b1, 2'd1, 1'b0);
    run_master(8'h5A, 8'hC3, 1'b0, 1'b0, 2'd1, 1'b1);
    run_master(8'h96, 8'h69, 1'b1, 1'b1, 2'd0, 1'b1);
    for (int i = 0; i < 16; i++)
      run_master(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                 2'($urandom), 1'b0);

    // follower: every mode, then random, then realignment
    for (int m = 0; m < 4; m++)
      run_slave(8'hF0 ^ 8'(m), 8'h0F ^ 8'(m * 3), m[0], m[1]);
    for (int i = 0; i < 8; i++)
      run_slave(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
    run_abort(8'hB4, 8'hFF, 8'h2D, 1'b0, 1'b0);
    run_abort(8'h4B, 8'h00, 8'hD2, 1'b1, 1'b1);

    summary();
    $finish;
  end
endmodule